// File: doc/BRIEF.md
# AXI4-Lite Channel Buffer Bridge

This block is inserted on an AXI4-Lite link between a manager and a subordinate to decouple them in time. Each of the five channels (write address, write data, write response, read address, read data) runs through its own first-word fall-through queue. The payload fields of a channel, which are everything except its valid/ready pair, are packed into one queue word. The side that pushes into a queue sees ready whenever that queue has room. The side that pops sees valid whenever the queue holds a word, with the oldest word already on the bus.

The two data channels also report their occupancy, and each has a near-full flag and a near-empty flag compared against threshold parameters. Everything runs on a single rising-edge clock. The reset is asynchronous and active low, and it empties every queue.

Top module: `axl_buf_bridge`

## Requirements
- R1: Every channel delivers its words in the order they were accepted, with all fields intact. Address words carry the address and a 3-bit protection field. Write-data words carry the data and one strobe bit per byte, with strobe bit 0 qualifying data bits 7:0. Read-data words carry the data and a 2-bit response. Write-response words carry only the 2-bit response.
- R2: A push-side ready is high while its queue holds fewer than its depth in words. It is low while the queue is full, and a word offered then is not taken.
- R3: A pop-side valid is high exactly while its queue is non-empty. A word pushed at a clock edge is visible on the pop side, without any request, right after that edge.
- R4: While a pop-side valid is high and its ready is low, the valid stays high and the payload does not change.
- R5: A pop takes place on a cycle with valid and ready both high. A push and a pop in the same cycle on a non-empty queue leave the occupancy unchanged.
- R6: Each data-channel occupancy output gives the number of words held, from 0 up to the full depth, in log2(depth)+1 bits.
- R7: A data-channel near-full flag is high exactly while occupancy is at or above its full threshold (default 10).
- R8: A data-channel near-empty flag is high exactly while occupancy is at or below its empty threshold (default 10).
- R9: Asserting rst_n low empties every queue at once, without waiting for a clock edge. While reset is held, and for the cycle after it is released, every ready and valid output is low.
- R10: The channels are independent: a stalled word on one channel does not block transfers on another.
- R11: Each depth must be a power of two and at least 16, and each threshold must lie between 5 and depth minus 3. Elaboration rejects any other setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_aw_addr | input | ADDR_W | Write address from the manager |
| up_aw_prot | input | 3 | Write protection from the manager |
| up_aw_valid | input | 1 | Write address valid from the manager |
| up_aw_ready | output | 1 | Write address queue has room |
| dn_aw_addr | output | ADDR_W | Oldest write address toward the subordinate |
| dn_aw_prot | output | 3 | Oldest write protection toward the subordinate |
| dn_aw_valid | output | 1 | Write address queue non-empty |
| dn_aw_ready | input | 1 | Subordinate takes the write address |
| up_w_data | input | DATA_W | Write data from the manager |
| up_w_strb | input | DATA_W/8 | Byte strobes from the manager |
| up_w_valid | input | 1 | Write data valid from the manager |
| up_w_ready | output | 1 | Write data queue has room |
| dn_w_data | output | DATA_W | Oldest write data toward the subordinate |
| dn_w_strb | output | DATA_W/8 | Oldest byte strobes toward the subordinate |
| dn_w_valid | output | 1 | Write data queue non-empty |
| dn_w_ready | input | 1 | Subordinate takes the write data |
| dn_b_resp | input | 2 | Write response from the subordinate |
| dn_b_valid | input | 1 | Write response valid from the subordinate |
| dn_b_ready | output | 1 | Write response queue has room |
| up_b_resp | output | 2 | Oldest write response toward the manager |
| up_b_valid | output | 1 | Write response queue non-empty |
| up_b_ready | input | 1 | Manager takes the write response |
| up_ar_addr | input | ADDR_W | Read address from the manager |
| up_ar_prot | input | 3 | Read protection from the manager |
| up_ar_valid | input | 1 | Read address valid from the manager |
| up_ar_ready | output | 1 | Read address queue has room |
| dn_ar_addr | output | ADDR_W | Oldest read address toward the subordinate |
| dn_ar_prot | output | 3 | Oldest read protection toward the subordinate |
| dn_ar_valid | output | 1 | Read address queue non-empty |
| dn_ar_ready | input | 1 | Subordinate takes the read address |
| dn_r_data | input | DATA_W | Read data from the subordinate |
| dn_r_resp | input | 2 | Read response from the subordinate |
| dn_r_valid | input | 1 | Read data valid from the subordinate |
| dn_r_ready | output | 1 | Read data queue has room |
| up_r_data | output | DATA_W | Oldest read data toward the manager |
| up_r_resp | output | 2 | Oldest read response toward the manager |
| up_r_valid | output | 1 | Read data queue non-empty |
| up_r_ready | input | 1 | Manager takes the read data |
| w_level | output | log2(W_DEPTH)+1 | Write-data queue occupancy |
| w_near_full | output | 1 | Write-data occupancy at or above its full threshold |
| w_near_empty | output | 1 | Write-data occupancy at or below its empty threshold |
| r_level | output | log2(R_DEPTH)+1 | Read-data queue occupancy |
| r_near_full | output | 1 | Read-data occupancy at or above its full threshold |
| r_near_empty | output | 1 | Read-data occupancy at or below its empty threshold |

## Verification
Several behaviours are checked by the assertions on every clock edge: the ready gating at full occupancy, the hold of a stalled valid and its payload, that occupancy steps by exactly one or stays put according to the handshakes, that the flags rise only on the handshake that can raise them, and the quiet cycle after reset is released. Other behaviours can only be shown by the bench's scenarios, because they need a reference order or a value history. These are word ordering and field integrity across a full fill and drain, the exact threshold crossing points, a refused push at full depth, channel independence under a stall, and the asynchronous clear in the middle of traffic.

// File: rtl/axl_fifo_pkg.sv
package axl_fifo_pkg;

    localparam int PROT_W = 3;
    localparam int RESP_W = 2;

    // Minimum queue depth allowed for any channel.
    localparam int MIN_DEPTH = 16;
    // Thresholds must stay this far from the empty and full ends.
    localparam int TH_LOW_GAP  = 5;
    localparam int TH_HIGH_GAP = 3;

    function automatic bit depth_ok(input int depth);
        return (depth >= MIN_DEPTH) && ((depth & (depth - 1)) == 0);
    endfunction

    function automatic bit thresh_ok(input int th, input int depth);
        return (th >= TH_LOW_GAP) && (th <= depth - TH_HIGH_GAP);
    endfunction

    function automatic int level_width(input int depth);
        return $clog2(depth) + 1;
    endfunction

endpackage

// File: rtl/axl_reset_arm.sv
// Holds every push-side ready low for the first cycle after reset release.
module axl_reset_arm (
    input  logic clk,
    input  logic rst_n,
    output logic live
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

endmodule

// File: rtl/axl_fifo_core.sv
// First-word fall-through queue: the head word is always on out_data.
module axl_fifo_core #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             live,
    input  logic [WIDTH-1:0] in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic [WIDTH-1:0] out_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [LVL_W-1:0] level
);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             push;
    logic             pop;

    assign in_ready  = live && (level != LVL_W'(DEPTH));
    assign out_valid = (level != '0);
    assign out_data  = store[rd_ptr];
    assign push      = in_valid && in_ready;
    assign pop       = out_valid && out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // Storage needs no reset: a slot is only read after it was written.
    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= in_data;
    end

endmodule

// File: rtl/axl_level_mon.sv
// Threshold flags derived from a queue occupancy.
module axl_level_mon #(
    parameter int DEPTH    = 16,
    parameter int FULL_TH  = 10,
    parameter int EMPTY_TH = 10,
    localparam int LVL_W = $clog2(DEPTH) + 1
) (
    input  logic [LVL_W-1:0] level,
    output logic             near_full,
    output logic             near_empty
);

    always_comb begin
        near_full  = (level >= LVL_W'(FULL_TH));
        near_empty = (level <= LVL_W'(EMPTY_TH));
    end

endmodule

// File: rtl/axl_buf_bridge.sv
module axl_buf_bridge
    import axl_fifo_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int AW_DEPTH   = 16,
    parameter int W_DEPTH    = 16,
    parameter int B_DEPTH    = 16,
    parameter int AR_DEPTH   = 16,
    parameter int R_DEPTH    = 16,
    parameter int W_FULL_TH  = 10,
    parameter int W_EMPTY_TH = 10,
    parameter int R_FULL_TH  = 10,
    parameter int R_EMPTY_TH = 10,
    localparam int STRB_W = DATA_W / 8,
    localparam int W_LW   = $clog2(W_DEPTH) + 1,
    localparam int R_LW   = $clog2(R_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] up_aw_addr,
    input  logic [PROT_W-1:0] up_aw_prot,
    input  logic              up_aw_valid,
    output logic              up_aw_ready,
    output logic [ADDR_W-1:0] dn_aw_addr,
    output logic [PROT_W-1:0] dn_aw_prot,
    output logic              dn_aw_valid,
    input  logic              dn_aw_ready,
    input  logic [DATA_W-1:0] up_w_data,
    input  logic [STRB_W-1:0] up_w_strb,
    input  logic              up_w_valid,
    output logic              up_w_ready,
    output logic [DATA_W-1:0] dn_w_data,
    output logic [STRB_W-1:0] dn_w_strb,
    output logic              dn_w_valid,
    input  logic              dn_w_ready,
    input  logic [RESP_W-1:0] dn_b_resp,
    input  logic              dn_b_valid,
    output logic              dn_b_ready,
    output logic [RESP_W-1:0] up_b_resp,
    output logic              up_b_valid,
    input  logic              up_b_ready,
    input  logic [ADDR_W-1:0] up_ar_addr,
    input  logic [PROT_W-1:0] up_ar_prot,
    input  logic              up_ar_valid,
    output logic              up_ar_ready,
    output logic [ADDR_W-1:0] dn_ar_addr,
    output logic [PROT_W-1:0] dn_ar_prot,
    output logic              dn_ar_valid,
    input  logic              dn_ar_ready,
    input  logic [DATA_W-1:0] dn_r_data,
    input  logic [RESP_W-1:0] dn_r_resp,
    input  logic              dn_r_valid,
    output logic              dn_r_ready,
    output logic [DATA_W-1:0] up_r_data,
    output logic [RESP_W-1:0] up_r_resp,
    output logic              up_r_valid,
    input  logic              up_r_ready,
    output logic [W_LW-1:0]   w_level,
    output logic              w_near_full,
    output logic              w_near_empty,
    output logic [R_LW-1:0]   r_level,
    output logic              r_near_full,
    output logic              r_near_empty
);

    // R11: configuration rules enforced at elaboration.
    localparam bit CFG_OK = depth_ok(AW_DEPTH) && depth_ok(W_DEPTH) && depth_ok(B_DEPTH)
                         && depth_ok(AR_DEPTH) && depth_ok(R_DEPTH)
                         && thresh_ok(W_FULL_TH, W_DEPTH) && thresh_ok(W_EMPTY_TH, W_DEPTH)
                         && thresh_ok(R_FULL_TH, R_DEPTH) && thresh_ok(R_EMPTY_TH, R_DEPTH)
                         && (STRB_W * 8 == DATA_W);
    generate
        if (!CFG_OK) begin : g_bad_cfg
            $error("axl_buf_bridge: depth or threshold setting out of range");
        end
    endgenerate

    // Packed channel words: payload fields only, handshakes excluded.
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [PROT_W-1:0] prot;
    } addr_word_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [STRB_W-1:0] strb;
    } wdat_word_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [RESP_W-1:0] resp;
    } rdat_word_t;

    logic live;

    addr_word_t aw_in, aw_out, ar_in, ar_out;
    wdat_word_t w_in, w_out;
    rdat_word_t r_in, r_out;
    logic [AW_DEPTH == 0 ? 0 : $clog2(AW_DEPTH):0] aw_level;
    logic [$clog2(B_DEPTH):0]  b_level;
    logic [$clog2(AR_DEPTH):0] ar_level;

    axl_reset_arm u_arm (
        .clk   (clk),
        .rst_n (rst_n),
        .live  (live)
    );

    // Write address: manager -> subordinate.
    assign aw_in      = '{addr: up_aw_addr, prot: up_aw_prot};
    assign dn_aw_addr = aw_out.addr;
    assign dn_aw_prot = aw_out.prot;

    axl_fifo_core #(.WIDTH($bits(addr_word_t)), .DEPTH(AW_DEPTH)) u_aw_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .live      (live),
        .in_data   (aw_in),
        .in_valid  (up_aw_valid),
        .in_ready  (up_aw_ready),
        .out_data  (aw_out),
        .out_valid (dn_aw_valid),
        .out_ready (dn_aw_ready),
        .level     (aw_level)
    );

    // Write data: manager -> subordinate.
    assign w_in      = '{data: up_w_data, strb: up_w_strb};
    assign dn_w_data = w_out.data;
    assign dn_w_strb = w_out.strb;

    axl_fifo_core #(.WIDTH($bits(wdat_word_t)), .DEPTH(W_DEPTH)) u_w_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .live      (live),
        .in_data   (w_in),
        .in_valid  (up_w_valid),
        .in_ready  (up_w_ready),
        .out_data  (w_out),
        .out_valid (dn_w_valid),
        .out_ready (dn_w_ready),
        .level     (w_level)
    );

    axl_level_mon #(.DEPTH(W_DEPTH), .FULL_TH(W_FULL_TH), .EMPTY_TH(W_EMPTY_TH)) u_w_mon (
        .level      (w_level),
        .near_full  (w_near_full),
        .near_empty (w_near_empty)
    );

    // Write response: subordinate -> manager, response code only.
    axl_fifo_core #(.WIDTH(RESP_W), .DEPTH(B_DEPTH)) u_b_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .live      (live),
        .in_data   (dn_b_resp),
        .in_valid  (dn_b_valid),
        .in_ready  (dn_b_ready),
        .out_data  (up_b_resp),
        .out_valid (up_b_valid),
        .out_ready (up_b_ready),
        .level     (b_level)
    );

    // Read address: manager -> subordinate.
    assign ar_in      = '{addr: up_ar_addr, prot: up_ar_prot};
    assign dn_ar_addr = ar_out.addr;
    assign dn_ar_prot = ar_out.prot;

    axl_fifo_core #(.WIDTH($bits(addr_word_t)), .DEPTH(AR_DEPTH)) u_ar_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .live      (live),
        .in_data   (ar_in),
        .in_valid  (up_ar_valid),
        .in_ready  (up_ar_ready),
        .out_data  (ar_out),
        .out_valid (dn_ar_valid),
        .out_ready (dn_ar_ready),
        .level     (ar_level)
    );

    // Read data: subordinate -> manager.
    assign r_in      = '{data: dn_r_data, resp: dn_r_resp};
    assign up_r_data = r_out.data;
    assign up_r_resp = r_out.resp;

    axl_fifo_core #(.WIDTH($bits(rdat_word_t)), .DEPTH(R_DEPTH)) u_r_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .live      (live),
        .in_data   (r_in),
        .in_valid  (dn_r_valid),
        .in_ready  (dn_r_ready),
        .out_data  (r_out),
        .out_valid (up_r_valid),
        .out_ready (up_r_ready),
        .level     (r_level)
    );

    axl_level_mon #(.DEPTH(R_DEPTH), .FULL_TH(R_FULL_TH), .EMPTY_TH(R_EMPTY_TH)) u_r_mon (
        .level      (r_level),
        .near_full  (r_near_full),
        .near_empty (r_near_empty)
    );

endmodule

// File: rtl/axl_buf_bridge_chk.sv
module axl_buf_bridge_chk #(
    parameter int W_DEPTH = 16,
    parameter int R_DEPTH = 16,
    parameter int DATA_W  = 32,
    localparam int STRB_W = DATA_W / 8,
    localparam int W_LW   = $clog2(W_DEPTH) + 1,
    localparam int R_LW   = $clog2(R_DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_aw_ready,
    input logic              up_w_valid,
    input logic              up_w_ready,
    input logic [DATA_W-1:0] dn_w_data,
    input logic [STRB_W-1:0] dn_w_strb,
    input logic              dn_w_valid,
    input logic              dn_w_ready,
    input logic              dn_b_ready,
    input logic              up_ar_ready,
    input logic              dn_r_ready,
    input logic [DATA_W-1:0] up_r_data,
    input logic [1:0]        up_r_resp,
    input logic              up_r_valid,
    input logic              up_r_ready,
    input logic [W_LW-1:0]   w_level,
    input logic              w_near_full,
    input logic              w_near_empty,
    input logic [R_LW-1:0]   r_level
);

    logic w_push;
    logic w_pop;
    assign w_push = up_w_valid && up_w_ready;
    assign w_pop  = dn_w_valid && dn_w_ready;

    a_r2_w_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (w_level == W_LW'(W_DEPTH)) |-> !up_w_ready);

    a_r2_r_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (r_level == R_LW'(R_DEPTH)) |-> !dn_r_ready);

    a_r3_push_visible: assert property (@(posedge clk) disable iff (!rst_n)
        w_push |=> dn_w_valid);

    a_r4_w_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_w_valid && !dn_w_ready) |=> (dn_w_valid && $stable(dn_w_data) && $stable(dn_w_strb)));

    a_r4_r_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (up_r_valid && !up_r_ready) |=> (up_r_valid && $stable(up_r_data) && $stable(up_r_resp)));

    a_r5_both_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (w_push && w_pop) |=> $stable(w_level));

    a_r6_push_step: assert property (@(posedge clk) disable iff (!rst_n)
        (w_push && !w_pop) |=> (w_level == $past(w_level) + 1'b1));

    a_r6_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
        (w_pop && !w_push) |=> (w_level == $past(w_level) - 1'b1));

    a_r7_full_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(w_near_full) |-> $past(w_push));

    a_r8_empty_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(w_near_empty) |-> $past(w_pop));

    a_r9_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!up_aw_ready && !up_w_ready && !up_ar_ready && !dn_b_ready
                           && !dn_r_ready && !dn_w_valid && !up_r_valid));

endmodule

bind axl_buf_bridge axl_buf_bridge_chk #(
    .W_DEPTH (W_DEPTH),
    .R_DEPTH (R_DEPTH),
    .DATA_W  (DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .up_aw_ready  (up_aw_ready),
    .up_w_valid   (up_w_valid),
    .up_w_ready   (up_w_ready),
    .dn_w_data    (dn_w_data),
    .dn_w_strb    (dn_w_strb),
    .dn_w_valid   (dn_w_valid),
    .dn_w_ready   (dn_w_ready),
    .dn_b_ready   (dn_b_ready),
    .up_ar_ready  (up_ar_ready),
    .dn_r_ready   (dn_r_ready),
    .up_r_data    (up_r_data),
    .up_r_resp    (up_r_resp),
    .up_r_valid   (up_r_valid),
    .up_r_ready   (up_r_ready),
    .w_level      (w_level),
    .w_near_full  (w_near_full),
    .w_near_empty (w_near_empty),
    .r_level      (r_level)
);

// File: tb/axl_buf_bridge_test.sv
module axl_buf_bridge_test;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int STRB_W = DATA_W / 8;
    localparam int DEPTH  = 16;
    localparam int W_FTH  = 12;
    localparam int W_ETH  = 5;
    localparam int LW     = $clog2(DEPTH) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [ADDR_W-1:0] up_aw_addr = '0, dn_aw_addr, up_ar_addr = '0, dn_ar_addr;
    logic [2:0]        up_aw_prot = '0, dn_aw_prot, up_ar_prot = '0, dn_ar_prot;
    logic              up_aw_valid = 0, up_aw_ready, dn_aw_valid, dn_aw_ready = 0;
    logic              up_ar_valid = 0, up_ar_ready, dn_ar_valid, dn_ar_ready = 0;
    logic [DATA_W-1:0] up_w_data = '0, dn_w_data, dn_r_data = '0, up_r_data;
    logic [STRB_W-1:0] up_w_strb = '0, dn_w_strb;
    logic              up_w_valid = 0, up_w_ready, dn_w_valid, dn_w_ready = 0;
    logic [1:0]        dn_b_resp = '0, up_b_resp, dn_r_resp = '0, up_r_resp;
    logic              dn_b_valid = 0, dn_b_ready, up_b_valid, up_b_ready = 0;
    logic              dn_r_valid = 0, dn_r_ready, up_r_valid, up_r_ready = 0;
    logic [LW-1:0]     w_level, r_level;
    logic              w_near_full, w_near_empty, r_near_full, r_near_empty;

    axl_buf_bridge #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .AW_DEPTH(DEPTH), .W_DEPTH(DEPTH), .B_DEPTH(DEPTH), .AR_DEPTH(DEPTH), .R_DEPTH(DEPTH),
        .W_FULL_TH(W_FTH), .W_EMPTY_TH(W_ETH), .R_FULL_TH(10), .R_EMPTY_TH(10)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .up_aw_addr(up_aw_addr), .up_aw_prot(up_aw_prot), .up_aw_valid(up_aw_valid), .up_aw_ready(up_aw_ready),
        .dn_aw_addr(dn_aw_addr), .dn_aw_prot(dn_aw_prot), .dn_aw_valid(dn_aw_valid), .dn_aw_ready(dn_aw_ready),
        .up_w_data(up_w_data), .up_w_strb(up_w_strb), .up_w_valid(up_w_valid), .up_w_ready(up_w_ready),
        .dn_w_data(dn_w_data), .dn_w_strb(dn_w_strb), .dn_w_valid(dn_w_valid), .dn_w_ready(dn_w_ready),
        .dn_b_resp(dn_b_resp), .dn_b_valid(dn_b_valid), .dn_b_ready(dn_b_ready),
        .up_b_resp(up_b_resp), .up_b_valid(up_b_valid), .up_b_ready(up_b_ready),
        .up_ar_addr(up_ar_addr), .up_ar_prot(up_ar_prot), .up_ar_valid(up_ar_valid), .up_ar_ready(up_ar_ready),
        .dn_ar_addr(dn_ar_addr), .dn_ar_prot(dn_ar_prot), .dn_ar_valid(dn_ar_valid), .dn_ar_ready(dn_ar_ready),
        .dn_r_data(dn_r_data), .dn_r_resp(dn_r_resp), .dn_r_valid(dn_r_valid), .dn_r_ready(dn_r_ready),
        .up_r_data(up_r_data), .up_r_resp(up_r_resp), .up_r_valid(up_r_valid), .up_r_ready(up_r_ready),
        .w_level(w_level), .w_near_full(w_near_full), .w_near_empty(w_near_empty),
        .r_level(r_level), .r_near_full(r_near_full), .r_near_empty(r_near_empty)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 20000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Write-data walk: op 1 push, 2 pop, 3 push and pop; level and flags after the run.
    typedef struct packed {
        logic [1:0] op;
        logic [4:0] reps;
        logic [4:0] lvl;
        logic       nf;
        logic       ne;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{2'd1, 5'd5, 5'd5,  1'b0, 1'b1},
        '{2'd1, 5'd1, 5'd6,  1'b0, 1'b0},
        '{2'd3, 5'd3, 5'd6,  1'b0, 1'b0},
        '{2'd1, 5'd5, 5'd11, 1'b0, 1'b0},
        '{2'd1, 5'd1, 5'd12, 1'b1, 1'b0},
        '{2'd1, 5'd4, 5'd16, 1'b1, 1'b0},
        '{2'd1, 5'd2, 5'd16, 1'b1, 1'b0},
        '{2'd2, 5'd4, 5'd12, 1'b1, 1'b0},
        '{2'd2, 5'd1, 5'd11, 1'b0, 1'b0},
        '{2'd2, 5'd6, 5'd5,  1'b0, 1'b1},
        '{2'd2, 5'd5, 5'd0,  1'b0, 1'b1},
        '{2'd2, 5'd2, 5'd0,  1'b0, 1'b1}
    };

    logic [DATA_W+STRB_W-1:0] wq [$];
    logic [DATA_W+1:0]        rq [$];

    initial begin
        logic [DATA_W-1:0] seq_val;
        logic acc, take;
        seq_val = 32'h1000_0000;

        // Reset state (R9)
        step(); step(); step();
        chk("R9 reset w ready", {63'd0, up_w_ready}, 64'd0);
        chk("R9 reset r ready", {63'd0, dn_r_ready}, 64'd0);
        chk("R9 reset w level", 64'(w_level), 64'd0);
        chk("R9 reset flags", {62'd0, w_near_full, w_near_empty}, 64'd1);
        chk("R9 reset valids", {61'd0, dn_w_valid, up_r_valid, up_b_valid}, 64'd0);
        rst_n = 1'b1;
        #1;
        chk("R9 first cycle after release ready low", {63'd0, up_aw_ready}, 64'd0);
        step();
        chk("R9 ready high once armed", {62'd0, up_aw_ready, up_w_ready}, 64'd3);

        // AW word parked with dn_aw_ready low (R1, R3, R10)
        up_aw_addr  = 32'hA5A5_0004;
        up_aw_prot  = 3'b101;
        up_aw_valid = 1'b1;
        step();
        up_aw_valid = 1'b0;
        chk("R3 aw visible next cycle", {63'd0, dn_aw_valid}, 64'd1);
        chk("R1 aw fields", {29'd0, dn_aw_addr, dn_aw_prot}, {29'd0, 32'hA5A5_0004, 3'b101});

        // Write-data table walk (R1, R2, R5, R6, R7, R8)
        foreach (VECS[v]) begin
            for (int k = 0; k < int'(VECS[v].reps); k++) begin
                up_w_valid = VECS[v].op[0];
                dn_w_ready = VECS[v].op[1];
                up_w_data  = seq_val;
                up_w_strb  = seq_val[3:0] ^ 4'b1010;
                #1;
                acc  = up_w_valid && up_w_ready;
                take = dn_w_valid && dn_w_ready;
                chk("R2 w ready vs room", {63'd0, up_w_ready}, {63'd0, wq.size() < DEPTH});
                chk("R3 w valid vs held", {63'd0, dn_w_valid}, {63'd0, wq.size() != 0});
                if (take) chk("R1 w order and strobes", 64'({dn_w_data, dn_w_strb}), 64'(wq[0]));
                step();
                if (acc) begin
                    wq.push_back({up_w_data, up_w_strb});
                    seq_val++;
                end
                if (take) void'(wq.pop_front());
            end
            up_w_valid = 1'b0;
            dn_w_ready = 1'b0;
            chk($sformatf("R6 w level after vector %0d", v), 64'(w_level), 64'(VECS[v].lvl));
            chk($sformatf("R7 near full after vector %0d", v), {63'd0, w_near_full}, {63'd0, VECS[v].nf});
            chk($sformatf("R8 near empty after vector %0d", v), {63'd0, w_near_empty}, {63'd0, VECS[v].ne});
        end

        // AW word still parked and unchanged (R4, R10)
        chk("R10 aw untouched by w traffic", {63'd0, dn_aw_valid}, 64'd1);
        chk("R4 aw payload held", 64'(dn_aw_addr), 64'h0000_0000_A5A5_0004);
        dn_aw_ready = 1'b1;
        step();
        dn_aw_ready = 1'b0;
        chk("R5 aw popped", {63'd0, dn_aw_valid}, 64'd0);

        // Write response path (R1, R3)
        dn_b_resp  = 2'b10;
        dn_b_valid = 1'b1;
        step();
        dn_b_valid = 1'b0;
        chk("R1 b response", {61'd0, up_b_valid, up_b_resp}, {61'd0, 1'b1, 2'b10});
        up_b_ready = 1'b1;
        step();
        up_b_ready = 1'b0;
        chk("R5 b popped", {63'd0, up_b_valid}, 64'd0);

        // Read address path with immediate acceptance downstream (R1, R3)
        up_ar_addr  = 32'h0000_0FF0;
        up_ar_prot  = 3'b010;
        up_ar_valid = 1'b1;
        dn_ar_ready = 1'b1;
        #1;
        chk("R3 ar not visible before the edge", {63'd0, dn_ar_valid}, 64'd0);
        step();
        up_ar_valid = 1'b0;
        chk("R1 ar fields", {29'd0, dn_ar_addr, dn_ar_prot}, {29'd0, 32'h0000_0FF0, 3'b010});
        step();
        dn_ar_ready = 1'b0;
        chk("R5 ar drained", {63'd0, dn_ar_valid}, 64'd0);

        // Read data: fill 11 with default thresholds 10/10 (R6, R7, R8)
        for (int k = 0; k < 11; k++) begin
            dn_r_data  = 32'hBEEF_0000 + 32'(k * 3);
            dn_r_resp  = 2'(k);
            dn_r_valid = 1'b1;
            rq.push_back({dn_r_data, dn_r_resp});
            step();
            if (k == 9) begin
                chk("R7 r near full at 10", {63'd0, r_near_full}, 64'd1);
                chk("R8 r near empty at 10", {63'd0, r_near_empty}, 64'd1);
            end
        end
        dn_r_valid = 1'b0;
        chk("R6 r level 11", 64'(r_level), 64'd11);
        chk("R8 r near empty off at 11", {63'd0, r_near_empty}, 64'd0);
        up_r_ready = 1'b1;
        for (int k = 0; k < 11; k++) begin
            #1;
            chk("R1 r order and response", 64'({up_r_data, up_r_resp}), 64'(rq[0]));
            void'(rq.pop_front());
            step();
        end
        up_r_ready = 1'b0;
        chk("R3 r valid low when empty", {63'd0, up_r_valid}, 64'd0);

        // Asynchronous clear in the middle of traffic (R9)
        dn_r_valid = 1'b1;
        dn_r_data  = 32'h1234_5678;
        step(); step(); step();
        dn_r_valid = 1'b0;
        chk("R6 r level before clear", 64'(r_level), 64'd3);
        #1;
        rst_n = 1'b0;
        #1;
        chk("R9 async clear level", 64'(r_level), 64'd0);
        chk("R9 async clear valid and ready", {62'd0, up_r_valid, dn_r_ready}, 64'd0);
        step();
        rst_n = 1'b1;
        #1;
        chk("R9 r ready low right after release", {63'd0, dn_r_ready}, 64'd0);
        step();
        chk("R9 r ready high after one cycle", {63'd0, dn_r_ready}, 64'd1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule